// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Fill Trigger

This block holds received serial characters until the processor collects them. A line receiver pushes each byte as it arrives. The processor pops bytes from the front of the queue. The queue holds sixteen bytes. A 2-bit trigger select picks one of four fill thresholds. When the fill reaches the threshold, a data-ready flag is raised, and an interrupt is raised with it if the interrupt is enabled.

The oldest byte is always present on `head_data`. A pop request consumes that byte on the next clock edge. The flag and the interrupt are sticky state. They change only when a push or a pop is accepted, when the queue is cleared, or when the interrupt enable falls. They do not track the threshold continuously, so the flag drops only when a pop takes the fill below the active threshold.

Top module: `rxq_trig_fifo`

## Requirements
- R1: The queue holds up to 16 bytes. `fill_count` ranges from 0 to 16. Bytes leave in the order they arrived, and the read and write positions wrap from the last slot back to the first.
- R2: Each clock edge samples `trig_sel` into a threshold register, and the new value applies from the following cycle. The encodings are 0 for 1 byte, 1 for 4 bytes, 2 for 8 bytes and 3 for 14 bytes.
- R3: Reset is synchronous and active low. It leaves the queue empty, `data_full` and `rx_irq` low, and the threshold at 1 byte, whatever `trig_sel` holds.
- R4: A push is accepted when `push_valid` and `rx_en` are high and the fill at the start of the cycle is below 16. When the queue is full, the push is dropped without any effect.
- R5: `data_full` is set when an accepted push leaves the fill at or above the threshold.
- R6: `head_data` shows the oldest byte whenever the fill is nonzero. An accepted pop removes that byte and lowers the fill by one. With an empty queue, `head_data` reads 8'hFF and a pop has no effect.
- R7: `data_full` clears when an accepted pop leaves the fill below the threshold. A change of `trig_sel` alone never changes `data_full`.
- R8: `rx_irq` rises together with `data_full` when `rx_ie` is high. It falls when `data_full` clears, and it falls at the next edge after `rx_ie` is sampled low. It is never high while `data_full` is low.
- R9: `clear` empties the queue and drops `data_full` and `rx_irq` at the next edge. A push or pop in the same cycle is ignored.
- R10: When a push and a pop are both accepted in one cycle, the fill is unchanged and both positions advance. Afterwards, `data_full` equals (fill >= threshold).
- R11: While `rx_en` is low, pushes are ignored and the contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | A received byte is offered this cycle |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Consume the byte on head_data |
| clear | input | 1 | Synchronous flush of the queue and its status |
| trig_sel | input | 2 | Fill threshold select (1, 4, 8 or 14 bytes) |
| rx_en | input | 1 | Receive enable; pushes are ignored when low |
| rx_ie | input | 1 | Interrupt enable |
| head_data | output | 8 | Oldest byte, or 8'hFF when the queue is empty |
| fill_count | output | 5 | Number of bytes held |
| data_full | output | 1 | Fill has reached the threshold |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A push and a pop can fall in the same cycle. This matters most at the empty and full boundaries and right at the threshold, because the flag rule then has to pick between a set and a clear. Random phases with high push and high pop rates make the two overlap often. Directed steps force the overlap when the fill equals the threshold and when the queue is full. A cycle-level bench model predicts the head byte, the fill, the flag and the interrupt after each edge, and every cycle is judged against it. A clear arriving together with a push or a pop is also provoked, to show that the flush takes priority.

// File: rtl/rxq_pkg.sv
// Package: shared constants and the trigger decode for the receive queue.
// Assumes: callers size their threshold signals with enough bits for 14.
package rxq_pkg;

    localparam int RXQ_DEPTH = 16;
    localparam int RXQ_DW    = 8;

    // Decode the 2-bit trigger select into a byte threshold.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Module: byte storage for the receive queue.
// One write port and one asynchronous read port. Slots are not reset,
// because occupancy is tracked elsewhere.
// Assumes: wr_addr and rd_addr are always below DEPTH.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted byte into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the slot at the read position.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rxq_ptrs.sv
// Module: read/write positions and fill counter of the receive queue.
// Decides push and pop acceptance. The full test uses the fill at the start
// of the cycle. Clear wins over both push and pop.
// Assumes: DEPTH >= 2.
module rxq_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push_valid,
    input  logic          rx_en,
    input  logic          pop_req,
    output logic          push_acc,
    output logic          pop_acc,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);

    logic [AW-1:0] wr_inc;
    logic [AW-1:0] rd_inc;

    assign push_acc = push_valid && rx_en && (count < CW'(DEPTH)) && !clear;
    assign pop_acc  = pop_req && (count != '0) && !clear;

    // Pick the wrap style: free-running for a power of two, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wr_inc = wr_ptr + AW'(1);
            assign rd_inc = rd_ptr + AW'(1);
        end else begin : g_cmp_wrap
            assign wr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            assign rd_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    endgenerate

    // Next fill level from the accepted operations.
    always_comb begin
        case ({push_acc, pop_acc})
            2'b10:   count_nxt = count + CW'(1);
            2'b01:   count_nxt = count - CW'(1);
            default: count_nxt = count;
        endcase
    end

    // Advance positions and fill, or flush them.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) begin
                wr_ptr <= wr_inc;
            end
            if (pop_acc) begin
                rd_ptr <= rd_inc;
            end
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/rxq_flags.sv
// Module: threshold register, data-ready flag and interrupt of the queue.
// The flag and the interrupt are event-driven: set by a push that reaches
// the threshold, cleared by a pop that falls below it, or by a clear.
// Assumes: push_acc and pop_acc are already low during a clear.
module rxq_flags #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [1:0]    trig_sel,
    input  logic          rx_ie,
    input  logic          push_acc,
    input  logic          pop_acc,
    input  logic [CW-1:0] count_nxt,
    output logic          data_full,
    output logic          rx_irq
);

    localparam int TW = (CW > 4) ? CW : 4;

    logic [TW-1:0] thr_q;
    logic [TW-1:0] cnt_ext;
    logic          set_ev;
    logic          clr_ev;

    assign cnt_ext = TW'(count_nxt);
    assign set_ev  = push_acc && (cnt_ext >= thr_q);
    assign clr_ev  = pop_acc && (cnt_ext < thr_q);

    // Sample the trigger select; the reset value gives a 1-byte threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= TW'(1);
        end else begin
            thr_q <= TW'(rxq_pkg::trig_level(trig_sel));
        end
    end

    // Sticky data-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            data_full <= 1'b0;
        end else if (set_ev) begin
            data_full <= 1'b1;
        end else if (clr_ev) begin
            data_full <= 1'b0;
        end
    end

    // Interrupt: follows flag events, masked low by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !rx_ie) begin
            rx_irq <= 1'b0;
        end else if (set_ev) begin
            rx_irq <= 1'b1;
        end else if (clr_ev) begin
            rx_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_trig_fifo.sv
// Module: top of the receive queue with programmable fill trigger.
// Connects storage, position control and flag logic, and substitutes
// all-ones for the head byte when the queue is empty.
// Assumes: one push and one pop at most per cycle.
module rxq_trig_fifo #(
    parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
    parameter int DW    = rxq_pkg::RXQ_DW,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    input  logic          clear,
    input  logic [1:0]    trig_sel,
    input  logic          rx_en,
    input  logic          rx_ie,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] fill_count,
    output logic          data_full,
    output logic          rx_irq
);

    logic          push_acc;
    logic          pop_acc;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count_nxt;
    logic [DW-1:0] rd_data;

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .push_valid (push_valid),
        .rx_en      (rx_en),
        .pop_req    (pop_req),
        .push_acc   (push_acc),
        .pop_acc    (pop_acc),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .count      (fill_count),
        .count_nxt  (count_nxt)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (push_acc),
        .wr_addr (wr_ptr),
        .wr_data (push_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .trig_sel  (trig_sel),
        .rx_ie     (rx_ie),
        .push_acc  (push_acc),
        .pop_acc   (pop_acc),
        .count_nxt (count_nxt),
        .data_full (data_full),
        .rx_irq    (rx_irq)
    );

    // Oldest byte when occupied, all-ones when empty.
    assign head_data = (fill_count != '0) ? rd_data : '1;

endmodule

// File: rtl/rxq_trig_fifo_chk.sv
// Module: assertion checker for the receive queue, bound to the top.
// Observes only the top-level ports.
module rxq_trig_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          pop_req,
    input logic          clear,
    input logic          rx_en,
    input logic          rx_ie,
    input logic [DW-1:0] head_data,
    input logic [CW-1:0] fill_count,
    input logic          data_full,
    input logic          rx_irq
);

    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH)); // R1

    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CW'(DEPTH) && push_valid && rx_en && !pop_req && !clear)
        |=> fill_count == CW'(DEPTH)); // R4

    AST_EMPTY_HEAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> (head_data == '1)); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> data_full); // R8

    AST_IE_LOW_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie |=> !rx_irq); // R8

    AST_CLEAR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill_count == '0 && !data_full && !rx_irq)); // R9

    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && rx_en && pop_req && !clear && fill_count != '0
         && fill_count != CW'(DEPTH)) |=> $stable(fill_count)); // R10

    AST_RXEN_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !pop_req && !clear) |=> $stable(fill_count)); // R11

endmodule

bind rxq_trig_fifo rxq_trig_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .clear      (clear),
    .rx_en      (rx_en),
    .rx_ie      (rx_ie),
    .head_data  (head_data),
    .fill_count (fill_count),
    .data_full  (data_full),
    .rx_irq     (rx_irq)
);

// File: tb/rxq_trig_fifo_tb_top.sv
module rxq_trig_fifo_tb_top;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop_req = 1'b0;
    logic       clear = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rx_en = 1'b1;
    logic       rx_ie = 1'b1;
    logic [7:0] head_data;
    logic [4:0] fill_count;
    logic       data_full;
    logic       rx_irq;

    always #4 clk = ~clk;

    rxq_trig_fifo dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop_req    (pop_req),
        .clear      (clear),
        .trig_sel   (trig_sel),
        .rx_en      (rx_en),
        .rx_ie      (rx_ie),
        .head_data  (head_data),
        .fill_count (fill_count),
        .data_full  (data_full),
        .rx_irq     (rx_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [7:0] mq [DEPTH];
    int m_wr = 0, m_rd = 0, m_cnt = 0, m_thr = 1;
    bit m_flag = 1'b0, m_irq = 1'b0;

    function automatic int thr_map(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int exp_head();
        return (m_cnt != 0) ? int'(mq[m_rd]) : 8'hFF;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        check("R6 head_data", int'(head_data), exp_head());
        check("R1 fill_count", int'(fill_count), m_cnt);
        check("R5 R7 data_full", int'(data_full), int'(m_flag));
        check("R8 rx_irq", int'(rx_irq), int'(m_irq));
    endtask

    task automatic model_update();
        bit pa, po, set_ev, clr_ev;
        int nc;
        if (!rst_n) begin
            m_wr = 0; m_rd = 0; m_cnt = 0; m_thr = 1; m_flag = 0; m_irq = 0;
            return;
        end
        if (clear) begin
            m_wr = 0; m_rd = 0; m_cnt = 0; m_flag = 0; m_irq = 0;
        end else begin
            pa = push_valid && rx_en && (m_cnt < DEPTH);
            po = pop_req && (m_cnt > 0);
            if (pa) begin
                mq[m_wr] = push_data;
                m_wr = (m_wr + 1) % DEPTH;
            end
            if (po) m_rd = (m_rd + 1) % DEPTH;
            nc = m_cnt + int'(pa) - int'(po);
            set_ev = pa && (nc >= m_thr);
            clr_ev = po && (nc < m_thr);
            if (set_ev) m_flag = 1;
            else if (clr_ev) m_flag = 0;
            if (!rx_ie) m_irq = 0;
            else if (set_ev) m_irq = 1;
            else if (clr_ev) m_irq = 0;
            m_cnt = nc;
        end
        m_thr = thr_map(trig_sel);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        push_valid = 0; pop_req = 0; clear = 0;
    endtask

    task automatic drive_rand(input int pp, input int pop_pct);
        push_valid = ($urandom_range(99) < pp);
        push_data  = 8'($urandom);
        pop_req    = ($urandom_range(99) < pop_pct);
        clear      = ($urandom_range(199) == 0);
        rx_en      = ($urandom_range(19) != 0);
        rx_ie      = ($urandom_range(9) != 0);
        if ($urandom_range(31) == 0) trig_sel = 2'($urandom);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R3: reset holds the queue empty although a push is pending
        trig_sel = 2'd3; push_valid = 1; push_data = 8'hA5; rx_en = 1; rx_ie = 1;
        repeat (3) cycle();
        check("R3 reset fill", int'(fill_count), 0);
        check("R3 reset head", int'(head_data), 8'hFF);
        check("R3 reset flag", int'(data_full), 0);
        // R3: first edge after reset still uses the 1-byte threshold
        rst_n = 1;
        cycle();
        check("R3 threshold one after reset", int'(data_full), 1);
        check("R3 irq with flag", int'(rx_irq), 1);
        idle();
        // R7: threshold now 14, trigger change leaves flag set
        cycle();
        check("R7 flag held on trig change", int'(data_full), 1);
        // R2 R7: pop to zero drops flag (0 < 14)
        pop_req = 1; cycle(); idle();
        check("R7 flag cleared by pop", int'(data_full), 0);

        // R4 R1: fill beyond depth with trig 3
        for (int i = 0; i < 20; i++) begin
            push_valid = 1; push_data = 8'(i + 16); cycle();
            if (i == 12) check("R2 flag low at 13 bytes thr 14", int'(data_full), 0);
            if (i == 13) check("R2 flag high at 14 bytes thr 14", int'(data_full), 1);
        end
        idle();
        check("R4 full drops push", int'(fill_count), 16);
        check("R1 oldest byte kept", int'(head_data), 16);
        // R10: push and pop on a full queue: push dropped, pop taken
        push_valid = 1; pop_req = 1; push_data = 8'hEE; cycle();
        check("R4 full push dropped under pop", int'(fill_count), 15);
        // R10: now both accepted, fill holds at 15
        cycle();
        check("R10 push+pop hold", int'(fill_count), 15);
        idle();
        // R11: rx_en low blocks pushes
        rx_en = 0; push_valid = 1; cycle(); cycle(); idle(); rx_en = 1;
        check("R11 rx_en low ignores push", int'(fill_count), 15);
        // R8: interrupt falls when enable drops
        rx_ie = 0; cycle();
        check("R8 irq masked", int'(rx_irq), 0);
        rx_ie = 1;
        // R1 R6: drain in order, then pop on empty
        for (int i = 0; i < 17; i++) begin
            pop_req = 1; cycle();
        end
        idle();
        check("R6 empty pop ignored", int'(fill_count), 0);
        check("R6 empty head ones", int'(head_data), 8'hFF);
        // R10: push+pop at threshold boundary with thr 4
        trig_sel = 2'd1; cycle();
        for (int i = 0; i < 4; i++) begin
            push_valid = 1; push_data = 8'(i + 100); cycle();
        end
        idle();
        check("R5 flag at 4 bytes thr 4", int'(data_full), 1);
        push_valid = 1; pop_req = 1; push_data = 8'h77; cycle(); idle();
        check("R10 flag stays at threshold", int'(data_full), 1);
        // R9: clear beats push and pop
        clear = 1; push_valid = 1; pop_req = 1; cycle(); idle();
        check("R9 clear empties", int'(fill_count), 0);
        check("R9 clear drops flag", int'(data_full), 0);

        // Random phases: balanced, push heavy, pop heavy, overlap heavy
        for (int ph = 0; ph < 8; ph++) begin
            for (int i = 0; i < 400; i++) begin
                case (ph % 4)
                    0: drive_rand(50, 50);
                    1: drive_rand(85, 20);
                    2: drive_rand(20, 85);
                    default: drive_rand(90, 90);
                endcase
                cycle();
            end
        end
        idle();
        cycle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule